// File: doc/BRIEF.md
# Dual-Input Edge Timestamp Unit

This peripheral records when two asynchronous input pins change level. A 16-bit counter advances by one on every capture-clock tick (a single-cycle enable on the system clock). Each pin passes through a short synchronizer clocked by that tick. When a rising or falling transition reaches the end of the synchronizer, the current counter value is stored in the capture register for that pin and direction. One capture register exists for each of the four pin/direction pairs. In the normal byte mode, a prescale field picks which eight adjacent counter bits are kept. This trades resolution against range.

Software reaches the block through a small register bus with an address, write data, write and read strobes, and combinational read data. Through that bus it sets the capture options, enables events and clears pending status. Two options change how the captures behave. With first-edge hold, a capture register keeps its first timestamp and ignores later edges until software reads it. In the wide mode, pin 1 is switched off and its two registers act as the high bytes of pin 0's timestamps, giving a full 16-bit capture. Each pin has its own level-sensitive interrupt line.

Top module: `edge_stamp_timer`

## Requirements
- R1: After reset the counter, every capture register, the configuration, the enable register and the status register are zero, and both interrupt outputs are low.
- R2: The 16-bit counter increments by one, wrapping, on each cycle with `cap_tick` high. Capture registers change only in cycles where `cap_tick` is high.
- R3: A level change on a pin is captured at the third tick after it is first sampled high or low. The stored value is the counter value held just before that tick.
- R4: Configuration register at 0x2A: bit 7 first-edge hold, bits 6:4 prescale p, bit 3 wide mode, bits 2:0 read as 0. In byte mode a capture stores counter bits [7+p:p].
- R5: With first-edge hold clear, each capture register holds the most recent edge. With it set, a capture register ignores edges after a load until it is read with `bus_rd`. A read in the same cycle as an edge lets that edge load.
- R6: In wide mode, pin 1 edges are ignored. A pin 0 rise loads counter[7:0] into 0x22 and counter[15:8] into 0x23. A pin 0 fall loads the same halves into 0x24 and 0x25. Status sets only bit 0 or bit 1, and a read of 0x22 or 0x24 releases the hold for that pair.
- R7: Status register at 0x2C has bit 0 pin0-rise, bit 1 pin0-fall, bit 2 pin1-rise and bit 3 pin1-fall. A bit sets when its capture register loads. Writing 1 to a bit clears it, a set in the same cycle wins over the clear, and bits 7:4 read 0.
- R8: Enable register at 0x2B uses the same bit order in bits 3:0, with bits 7:4 reading 0. `irq0` is high while (status[1:0] AND enable[1:0]) is nonzero, and `irq1` does the same with bits 3:2.
- R9: Capture registers are read-only at 0x22 (pin0 rise), 0x23 (pin1 rise), 0x24 (pin0 fall) and 0x25 (pin1 fall), and writes to them have no effect. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_tick | input | 1 | Capture-clock enable, one cycle per tick |
| pin0 | input | 1 | Asynchronous input 0 |
| pin1 | input | 1 | Asynchronous input 1 |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (releases first-edge hold) |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq0 | output | 1 | Pin 0 interrupt, level |
| irq1 | output | 1 | Pin 1 interrupt, level |

## Verification
The bench checks the pulse width between a rise and a fall at 8 and 16 bits. A design with the wrong synchronizer depth or the wrong counter sample would store shifted values, and a design that dropped the high byte in wide mode would give a wrong 16-bit difference. Under first-edge hold it captures repeated pulses: a design that kept overwriting would show a changed value before the read, and one that never released would freeze after it. Random status writes are allowed to collide with captures, so a design where the clear beats the set loses interrupts. Pin 1 edges in wide mode must leave bits 3:2 clear.

// File: rtl/edge_stamp_timer.sv
`timescale 1ns/1ps
module edge_stamp_timer #(
  parameter int REG_W = 8,
  parameter int SYNC_N = 2,
  parameter logic [7:0] A_C0R = 8'h22,
  parameter logic [7:0] A_C1R = 8'h23,
  parameter logic [7:0] A_C0F = 8'h24,
  parameter logic [7:0] A_C1F = 8'h25,
  parameter logic [7:0] A_CFG = 8'h2A,
  parameter logic [7:0] A_IEN = 8'h2B,
  parameter logic [7:0] A_STS = 8'h2C
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_tick,
  input  logic             pin0,
  input  logic             pin1,
  input  logic [7:0]       bus_addr,
  input  logic [REG_W-1:0] bus_wdata,
  input  logic             bus_wr,
  input  logic             bus_rd,
  output logic [REG_W-1:0] bus_rdata,
  output logic             irq0,
  output logic             irq1
);
  localparam int CNT_W = 2 * REG_W;
  localparam int PS_W = 3;
  localparam logic [3:0][7:0] LANE_ADDR = {A_C1F, A_C1R, A_C0F, A_C0R};

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] shifted;
  logic [SYNC_N:0][1:0] sh;
  logic feh, wide;
  logic [PS_W-1:0] pre;
  logic [3:0] ien, sts, armed, rd_hit, ev, load, setb;
  logic [3:0][REG_W-1:0] cap_q;
  logic [1:0] rise, fall;
  logic wr_cfg, wr_ien, wr_sts;

  assign rise = {2{cap_tick}} & sh[SYNC_N-1] & ~sh[SYNC_N];
  assign fall = {2{cap_tick}} & ~sh[SYNC_N-1] & sh[SYNC_N];
  assign ev = {fall[1], rise[1], fall[0], rise[0]};
  assign shifted = cnt >> pre;

  assign wr_cfg = bus_wr && bus_addr == A_CFG;
  assign wr_ien = bus_wr && bus_addr == A_IEN;
  assign wr_sts = bus_wr && bus_addr == A_STS;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt <= '0;
      sh <= '0;
    end else if (cap_tick) begin
      cnt <= cnt + 1'b1;
      sh <= {sh[SYNC_N-1:0], {pin1, pin0}};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      feh <= 1'b0;
      pre <= '0;
      wide <= 1'b0;
      ien <= '0;
      sts <= '0;
    end else begin
      if (wr_cfg) {feh, pre, wide} <= bus_wdata[REG_W-1:REG_W-2-PS_W];
      if (wr_ien) ien <= bus_wdata[3:0];
      sts <= (sts & ~(wr_sts ? bus_wdata[3:0] : 4'h0)) | setb;
    end

  for (genvar k = 0; k < 4; k++) begin : g_lane
    logic ok;
    logic arm;
    logic [REG_W-1:0] val, q;

    assign rd_hit[k] = bus_rd && bus_addr == LANE_ADDR[k];

    if (k < 2) begin : g_low
      assign ok = !feh || arm || rd_hit[k];
      assign load[k] = ev[k] && ok;
      assign setb[k] = load[k];
      assign val = wide ? cnt[REG_W-1:0] : shifted[REG_W-1:0];
    end else begin : g_high
      assign ok = wide ? (!feh || armed[k-2] || rd_hit[k-2]) : (!feh || arm || rd_hit[k]);
      assign load[k] = wide ? (ev[k-2] && ok) : (ev[k] && ok);
      assign setb[k] = load[k] && !wide;
      assign val = wide ? cnt[CNT_W-1:REG_W] : shifted[REG_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        q <= '0;
        arm <= 1'b1;
      end else if (load[k]) begin
        q <= val;
        arm <= 1'b0;
      end else if (rd_hit[k]) begin
        arm <= 1'b1;
      end

    assign cap_q[k] = q;
    assign armed[k] = arm;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_C0R: bus_rdata = cap_q[0];
      A_C0F: bus_rdata = cap_q[1];
      A_C1R: bus_rdata = cap_q[2];
      A_C1F: bus_rdata = cap_q[3];
      A_CFG: bus_rdata = {feh, pre, wide, {(REG_W-2-PS_W){1'b0}}};
      A_IEN: bus_rdata = {{(REG_W-4){1'b0}}, ien};
      A_STS: bus_rdata = {{(REG_W-4){1'b0}}, sts};
      default: bus_rdata = '0;
    endcase
  end

  assign irq0 = |(sts[1:0] & ien[1:0]);
  assign irq1 = |(sts[3:2] & ien[3:2]);
endmodule

module edge_stamp_timer_chk #(
  parameter int REG_W = 8,
  parameter logic [7:0] A_STS = 8'h2C
) (
  input logic clk,
  input logic rst_n,
  input logic cap_tick,
  input logic bus_wr,
  input logic [7:0] bus_addr,
  input logic irq0,
  input logic irq1,
  input logic wide,
  input logic [3:0] ien,
  input logic [3:0] sts,
  input logic [3:0][REG_W-1:0] cap_q
);
  a_r2_quiet_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_tick |=> $stable(cap_q));

  a_r7_clear_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == A_STS) |=> ((sts & $past(sts)) == $past(sts)));

  a_r6_pin1_silent_in_wide: assert property (@(posedge clk) disable iff (!rst_n)
    wide |=> ((sts[3:2] & ~$past(sts[3:2])) == 2'b00));

  a_r8_irq0_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (ien[1:0] == 2'b00) |-> !irq0);

  a_r8_irq1_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (ien[3:2] == 2'b00) |-> !irq1);
endmodule

bind edge_stamp_timer edge_stamp_timer_chk #(.REG_W(REG_W), .A_STS(A_STS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cap_tick(cap_tick), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .irq0(irq0), .irq1(irq1), .wide(wide), .ien(ien), .sts(sts), .cap_q(cap_q)
);

// File: tb/test_edge_stamp_timer.sv
`timescale 1ns/1ps
module test_edge_stamp_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cap_tick = 1'b0;
  logic pin0 = 1'b0, pin1 = 1'b0;
  logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic irq0, irq1;

  always #2.5 clk = ~clk;

  edge_stamp_timer i_edge_stamp_timer (
    .clk(clk), .rst_n(rst_n), .cap_tick(cap_tick), .pin0(pin0), .pin1(pin1),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .irq0(irq0), .irq1(irq1)
  );

  int n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  bit tick_all = 1'b1;
  bit done = 1'b0;
  int rot = 0;

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // reference model
  int m_cnt, m_pre, m_ien, m_sts;
  bit m_feh, m_wide;
  int m_cap[4];
  bit m_arm[4];
  bit [1:0] m_hist[$];
  int lane_addr[4] = '{32'h22, 32'h24, 32'h23, 32'h25};

  function automatic int mread(int a);
    case (a)
      32'h22: return m_cap[0];
      32'h24: return m_cap[1];
      32'h23: return m_cap[2];
      32'h25: return m_cap[3];
      32'h2A: return (int'(m_feh) << 7) | (m_pre << 4) | (int'(m_wide) << 3);
      32'h2B: return m_ien;
      32'h2C: return m_sts;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_pre = 0; m_ien = 0; m_sts = 0; m_feh = 0; m_wide = 0;
      for (int k = 0; k < 4; k++) begin m_cap[k] = 0; m_arm[k] = 1; end
      m_hist.delete();
      for (int k = 0; k < 3; k++) m_hist.push_back(2'b00);
    end else begin
      bit e[4];
      bit ld[4];
      bit rdh[4];
      int nv[4];
      int setm, clrm, n;
      bit [1:0] cur, old;
      for (int k = 0; k < 4; k++) begin
        e[k] = 0;
        rdh[k] = bus_rd && (int'(bus_addr) == lane_addr[k]);
      end
      if (cap_tick) begin
        m_hist.push_back({pin1, pin0});
        n = m_hist.size();
        cur = m_hist[n-3];
        old = m_hist[n-4];
        void'(m_hist.pop_front());
        e[0] = cur[0] && !old[0];
        e[1] = !cur[0] && old[0];
        e[2] = cur[1] && !old[1];
        e[3] = !cur[1] && old[1];
      end
      setm = 0;
      for (int k = 0; k < 4; k++) begin
        int src;
        src = (m_wide && k >= 2) ? k - 2 : k;
        ld[k] = e[src] && (!m_feh || m_arm[src] || rdh[src]);
        if (m_wide) nv[k] = (k < 2) ? (m_cnt % 256) : (m_cnt / 256);
        else nv[k] = (m_cnt >> m_pre) % 256;
        if (ld[k] && !(m_wide && k >= 2)) setm |= (1 << k);
      end
      for (int k = 0; k < 4; k++) begin
        if (ld[k]) begin m_cap[k] = nv[k]; m_arm[k] = 0; end
        else if (rdh[k]) m_arm[k] = 1;
      end
      if (cap_tick) m_cnt = (m_cnt + 1) % 65536;
      clrm = 0;
      if (bus_wr) begin
        case (int'(bus_addr))
          32'h2A: begin m_feh = bus_wdata[7]; m_pre = int'(bus_wdata[6:4]); m_wide = bus_wdata[3]; end
          32'h2B: m_ien = int'(bus_wdata[3:0]);
          32'h2C: clrm = int'(bus_wdata[3:0]);
          default: ;
        endcase
      end
      m_sts = (m_sts & ~clrm) | setm;
    end
  end

  // per-cycle comparison away from the edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(cur_req, "irq0", int'(irq0), ((m_sts & m_ien & 3) != 0) ? 1 : 0);
      chk(cur_req, "irq1", int'(irq1), ((m_sts & m_ien & 12) != 0) ? 1 : 0);
      chk(cur_req, "rdata", int'(bus_rdata), mread(int'(bus_addr)));
    end
  end

  always @(posedge clk) begin
    #1 cap_tick = tick_all ? 1'b1 : ($urandom_range(0, 2) == 0);
  end

  task automatic idle(int n);
    repeat (n) begin
      @(posedge clk); #1;
      bus_addr = 8'h22 + 8'(rot % 11);
      rot++;
    end
  endtask

  task automatic wreg(logic [7:0] a, logic [7:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rreg(logic [7:0] a);
    @(posedge clk); #1;
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic peek(logic [7:0] a, output int v);
    @(posedge clk); #1;
    bus_addr = a;
    #1.5 v = int'(bus_rdata);
  endtask

  task automatic rcycles(int n);
    repeat (n) begin
      int op;
      @(posedge clk); #1;
      bus_wr = 1'b0; bus_rd = 1'b0;
      if ($urandom_range(0, 5) == 0) pin0 = ~pin0;
      if ($urandom_range(0, 6) == 0) pin1 = ~pin1;
      op = $urandom_range(0, 15);
      if (op < 2) begin
        bus_addr = 8'h22 + 8'($urandom_range(0, 3)); bus_rd = 1'b1;
      end else if (op < 4) begin
        bus_addr = 8'h2C; bus_wdata = 8'($urandom_range(0, 255)); bus_wr = 1'b1;
      end else if (op == 4) begin
        bus_addr = 8'h2B; bus_wdata = 8'($urandom_range(0, 255)); bus_wr = 1'b1;
      end else begin
        bus_addr = 8'h22 + 8'($urandom_range(0, 10));
      end
    end
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int v, v1, v2, v3, lo, hi;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state at the ports
    cur_req = "R1";
    foreach (lane_addr[k]) begin
      peek(8'(lane_addr[k]), v);
      chk("R1", "capture after reset", v, 0);
    end
    peek(8'h2C, v); chk("R1", "status after reset", v, 0);
    chk("R1", "irq0 after reset", int'(irq0), 0);
    chk("R1", "irq1 after reset", int'(irq1), 0);

    // R9: capture registers ignore writes; unmapped reads 0
    cur_req = "R9";
    wreg(8'h22, 8'h55);
    wreg(8'h25, 8'hAA);
    peek(8'h22, v); chk("R9", "write to 0x22 ignored", v, 0);
    peek(8'h25, v); chk("R9", "write to 0x25 ignored", v, 0);
    peek(8'h30, v); chk("R9", "unmapped read", v, 0);

    // R4 / R8: reserved bits
    cur_req = "R4";
    wreg(8'h2A, 8'hFF);
    peek(8'h2A, v); chk("R4", "config reserved bits", v, 8'hF8);
    wreg(8'h2A, 8'h00);
    cur_req = "R8";
    wreg(8'h2B, 8'hFF);
    peek(8'h2B, v); chk("R8", "enable reserved bits", v, 8'h0F);
    wreg(8'h2B, 8'h00);

    // R3: pulse width from capture difference
    cur_req = "R3";
    idle(4);
    pin0 = 1'b1;
    idle(10);
    pin0 = 1'b0;
    idle(6);
    peek(8'h22, lo); peek(8'h24, hi);
    chk("R3", "rise-to-fall distance", (hi - lo + 256) % 256, 10);
    cur_req = "R2";
    idle(300);

    // R7: write one to clear, R8: irq level
    cur_req = "R7";
    peek(8'h2C, v); chk("R7", "pin0 rise and fall pending", v & 3, 3);
    wreg(8'h2C, 8'h01);
    peek(8'h2C, v); chk("R7", "rise bit cleared, fall kept", v & 3, 2);
    wreg(8'h2C, 8'h0F);
    cur_req = "R8";
    wreg(8'h2B, 8'h01);
    pin0 = 1'b1; idle(6);
    chk("R8", "irq0 on enabled rise", int'(irq0), 1);
    chk("R8", "irq1 stays low", int'(irq1), 0);
    pin0 = 1'b0; idle(6);
    wreg(8'h2C, 8'h0F);
    wreg(8'h2B, 8'h00);

    // R5: first-edge hold
    cur_req = "R5";
    wreg(8'h2A, 8'h80);
    rreg(8'h22);
    pin0 = 1'b1; idle(5); pin0 = 1'b0; idle(6);
    peek(8'h22, v1);
    pin0 = 1'b1; idle(5); pin0 = 1'b0; idle(6);
    peek(8'h22, v2);
    chk("R5", "held first edge", v2, v1);
    rreg(8'h22);
    pin0 = 1'b1; idle(5); pin0 = 1'b0; idle(6);
    peek(8'h22, v3);
    chk("R5", "read releases hold", (v3 != v1) ? 1 : 0, 1);

    // R6: 16-bit mode
    cur_req = "R6";
    wreg(8'h2A, 8'h08);
    wreg(8'h2C, 8'h0F);
    pin1 = 1'b1; idle(5); pin1 = 1'b0; idle(6);
    peek(8'h2C, v); chk("R6", "pin1 ignored in wide mode", v & 12, 0);
    pin0 = 1'b1; idle(300); pin0 = 1'b0; idle(6);
    peek(8'h22, lo); peek(8'h23, hi); v1 = hi * 256 + lo;
    peek(8'h24, lo); peek(8'h25, hi); v2 = hi * 256 + lo;
    chk("R6", "16-bit pulse width", (v2 - v1 + 65536) % 65536, 300);

    // random phases against the model
    tick_all = 1'b0;
    for (int p = 0; p < 8; p++) begin
      cur_req = "R4";
      wreg(8'h2A, 8'(p << 4));
      rcycles(400);
    end
    cur_req = "R5";
    wreg(8'h2A, 8'hB0);
    rcycles(1500);
    cur_req = "R6";
    wreg(8'h2A, 8'h88);
    rcycles(1000);
    cur_req = "R7";
    wreg(8'h2A, 8'h08);
    tick_all = 1'b1;
    rcycles(1000);
    cur_req = "R2";
    wreg(8'h2A, 8'h70);
    rcycles(600);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule